// File: doc/BRIEF.md
# Eight-Lane Serial Sample Word Deserializer

This block rebuilds parallel sample words from the serial outputs of an eight-channel converter. Each channel arrives on its own one-bit lane. All lanes share one double-data-rate bit clock and one frame clock. Electrical reception and edge capture happen in front of the block. The core clock `clk` runs at twice the bit-clock rate, so each `clk` cycle carries the bit that was captured on one bit-clock edge, rising or falling. On each cycle the block therefore takes one bit from every lane and one sample of the frame clock.

A 0-to-1 step on the frame input marks the first bit of a word. Every lane is realigned at that point. Words are sent most significant bit first. A word is 14 bits long in normal mode and 12 bits long in short mode, which makes 7 or 6 bit-clock periods per sample. When a word is complete, all eight words are presented together with a one-cycle strobe. Each word is right-justified in a 16-bit field. The bits above the word are filled either with copies of the two's-complement sign bit or with zeros. A lock flag reports whether the frame marker keeps arriving at the expected spacing.

Top module: `adc_deser_top`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_o`, `lock_o` and every bit of `sample_o` are 0 after that edge.
- R2: The lane bit taken in the cycle where `frame_din` is 1 and was 0 in the previous cycle is the most significant bit of a new word. The following cycles supply the lower bits in descending order.
- R3: `valid_o` is high for exactly one cycle per complete word. It rises after the edge that takes the last bit of the word, and `sample_o` changes only at that same edge.
- R4: Lane l's word appears in `sample_o[16*l+15:16*l]`. Each lane is assembled only from its own `lane_din[l]`.
- R5: With `mode_short`=0 a word is 14 bits and frame markers are 14 cycles apart. With `mode_short`=1 a word is 12 bits and the spacing is 12 cycles.
- R6: With `sext_en`=1, every output bit above the word (bits 15..14 in 14-bit mode, 15..12 in 12-bit mode) equals the word's top bit.
- R7: With `sext_en`=0, those upper output bits are 0.
- R8: `lock_o` goes high at the frame marker that completes four consecutive marker spacings equal to the word length. The first marker after reset does not count as a spacing.
- R9: `lock_o` drops, and the run of good spacings restarts, at any marker that comes before the expected spacing. It also drops at the cycle where a marker was expected but did not arrive.
- R10: A marker that arrives before the current word is complete discards the partial word without a strobe. The next word is then assembled from the new marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one cycle per bit-clock edge |
| rst | input | 1 | Synchronous active-high reset |
| lane_din | input | 8 | One captured bit per lane for this edge |
| frame_din | input | 1 | Captured frame clock level for this edge |
| mode_short | input | 1 | 0: 14-bit words, 1: 12-bit words |
| sext_en | input | 1 | 1: sign-extend to 16 bits, 0: zero-fill |
| sample_o | output | 128 | Eight 16-bit words, lane 0 in the low bits |
| valid_o | output | 1 | One-cycle strobe when `sample_o` holds new words |
| lock_o | output | 1 | Frame marker spacing has been correct four times in a row |

## Verification
The first stimulus is a set of full-length frames in which every lane carries a different value. This shows up any swap between lanes and any bit-order error. Extreme two's-complement values (most negative, most positive, all ones, alternating bits) then tell sign extension apart from zero fill in both word lengths. A truncated frame followed by a normal one shows that a partial word is thrown away and that alignment is taken from the new marker, and it also checks the early-marker loss of lock. A gap in the markers checks the late-marker loss, and a run of good frames after each disturbance shows that lock is regained after exactly four spacings.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  localparam int unsigned LANES       = 8;
  localparam int unsigned W_LONG      = 14;
  localparam int unsigned W_SHORT     = 12;
  localparam int unsigned OUT_W       = 16;
  localparam int unsigned LOCK_FRAMES = 4;
endpackage

// File: rtl/adc_deser_framer.sv
module adc_deser_framer #(
  parameter int unsigned W_LONG      = 14,
  parameter int unsigned W_SHORT     = 12,
  parameter int unsigned LOCK_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_din,
  input  logic mode_short,
  output logic word_done,
  output logic lock_o
);
  localparam int unsigned CNT_W  = $clog2(2 * W_LONG + 1);
  localparam int unsigned GOOD_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
  localparam logic [GOOD_W-1:0] GOOD_TOP = GOOD_W'(LOCK_FRAMES);

  logic              frame_q;
  logic              seen_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GOOD_W-1:0] good_q, good_n;
  logic [CNT_W-1:0]  wlen;
  logic              rise;

  assign wlen      = mode_short ? CNT_W'(W_SHORT) : CNT_W'(W_LONG);
  assign rise      = frame_din & ~frame_q;
  assign word_done = seen_q & ~rise & (cnt_q == wlen - 1'b1);

  // spacing qualification: a marker exactly wlen cycles after the last one
  always_comb begin
    good_n = good_q;
    if (rise) begin
      if (seen_q && cnt_q == wlen)
        good_n = (good_q == GOOD_TOP) ? good_q : good_q + 1'b1;
      else
        good_n = '0;
    end else if (cnt_q == wlen) begin
      good_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
      good_q  <= '0;
      lock_o  <= 1'b0;
    end else begin
      frame_q <= frame_din;
      if (rise) begin
        cnt_q  <= CNT_W'(1);
        seen_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
      good_q <= good_n;
      lock_o <= (good_n == GOOD_TOP);
    end
  end
endmodule

// File: rtl/adc_deser_lane.sv
module adc_deser_lane #(
  parameter int unsigned W_LONG  = 14,
  parameter int unsigned W_SHORT = 12,
  parameter int unsigned OUT_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic             capture,
  input  logic             mode_short,
  input  logic             sext_en,
  output logic [OUT_W-1:0] word_o
);
  logic [W_LONG-2:0] sr_q;
  logic [W_LONG-1:0] raw;
  logic [OUT_W-1:0]  rawx;
  logic [OUT_W-1:0]  fmt;
  logic              sgn;

  assign raw  = {sr_q, din};
  assign rawx = OUT_W'(raw);
  assign sgn  = mode_short ? raw[W_SHORT-1] : raw[W_LONG-1];

  always_comb begin
    for (int b = 0; b < int'(OUT_W); b++) begin
      if (b < (mode_short ? int'(W_SHORT) : int'(W_LONG)))
        fmt[b] = rawx[b];
      else
        fmt[b] = sext_en & sgn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      word_o <= '0;
    end else begin
      sr_q <= {sr_q[W_LONG-3:0], din};
      if (capture)
        word_o <= fmt;
    end
  end
endmodule

// File: rtl/adc_deser_top.sv
module adc_deser_top
  import adc_deser_pkg::*;
#(
  parameter int unsigned N_LANES = LANES,
  parameter int unsigned WL      = W_LONG,
  parameter int unsigned WS      = W_SHORT,
  parameter int unsigned OW      = OUT_W,
  parameter int unsigned LOCK_N  = LOCK_FRAMES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_LANES-1:0]    lane_din,
  input  logic                  frame_din,
  input  logic                  mode_short,
  input  logic                  sext_en,
  output logic [N_LANES*OW-1:0] sample_o,
  output logic                  valid_o,
  output logic                  lock_o
);
  logic                          word_done;
  logic [N_LANES-1:0][OW-1:0]    words;

  adc_deser_framer #(
    .W_LONG(WL), .W_SHORT(WS), .LOCK_FRAMES(LOCK_N)
  ) framer_i (
    .clk(clk), .rst(rst), .frame_din(frame_din), .mode_short(mode_short),
    .word_done(word_done), .lock_o(lock_o)
  );

  for (genvar l = 0; l < int'(N_LANES); l++) begin : g_lane
    adc_deser_lane #(
      .W_LONG(WL), .W_SHORT(WS), .OUT_W(OW)
    ) lane_i (
      .clk(clk), .rst(rst), .din(lane_din[l]), .capture(word_done),
      .mode_short(mode_short), .sext_en(sext_en), .word_o(words[l])
    );
  end

  assign sample_o = words;

  always_ff @(posedge clk) begin
    if (rst) valid_o <= 1'b0;
    else     valid_o <= word_done;
  end
endmodule

// File: rtl/adc_deser_chk.sv
module adc_deser_chk #(
  parameter int unsigned N_LANES = 8,
  parameter int unsigned WL      = 14,
  parameter int unsigned WS      = 12,
  parameter int unsigned OW      = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  mode_short,
  input logic                  sext_en,
  input logic [N_LANES*OW-1:0] sample_o,
  input logic                  valid_o,
  input logic                  lock_o
);
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_data_moves_with_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_o) |-> valid_o);

  assert_sign_copy_R6: assert property (@(posedge clk) disable iff (rst)
    (valid_o && $past(sext_en) && !$past(mode_short)) |->
      (sample_o[OW-1:WL] == {(OW-WL){sample_o[WL-1]}}));

  assert_zero_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !$past(sext_en) && $past(mode_short)) |->
      (sample_o[OW-1:WS] == '0));

  assert_lock_follows_word_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(valid_o));
endmodule

bind adc_deser_top adc_deser_chk #(
  .N_LANES(N_LANES), .WL(WL), .WS(WS), .OW(OW)
) chk_i (
  .clk(clk), .rst(rst), .mode_short(mode_short), .sext_en(sext_en),
  .sample_o(sample_o), .valid_o(valid_o), .lock_o(lock_o)
);

// File: tb/adc_deser_top_tb_top.sv
module adc_deser_top_tb_top;
  import adc_deser_pkg::*;
  localparam int NL = LANES;
  localparam int OW = OUT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0] lane_din = '0;
  logic frame_din = 1'b0, mode_short = 1'b0, sext_en = 1'b0;
  logic [NL*OW-1:0] sample_o;
  logic valid_o, lock_o;

  int n_chk = 0, n_bad = 0;
  int early;
  logic got_valid;
  logic [W_LONG-1:0] tx [NL];

  always #4 clk = ~clk;

  adc_deser_top dut_i (
    .clk(clk), .rst(rst), .lane_din(lane_din), .frame_din(frame_din),
    .mode_short(mode_short), .sext_en(sext_en),
    .sample_o(sample_o), .valid_o(valid_o), .lock_o(lock_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] expect_word(input logic [W_LONG-1:0] raw, input int w, input logic sx);
    logic [OW-1:0] r;
    for (int b = 0; b < OW; b++)
      r[b] = (b < w) ? raw[b] : (sx & raw[w-1]);
    return r;
  endfunction

  task automatic fill(input int k);
    for (int l = 0; l < NL; l++) tx[l] = W_LONG'(k * 3355 + l * 1079 + 677);
  endtask

  // drive nbits edges of a frame; marker high for the first half
  task automatic send_frame(input int w, input int nbits);
    early = 0;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      frame_din = (i < nbits / 2);
      for (int l = 0; l < NL; l++) lane_din[l] = tx[l][w-1-i];
      @(posedge clk);
      #1;
      if (i < nbits - 1 && valid_o) early++;
    end
    got_valid = valid_o;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_din = 1'b0;
      lane_din  = '0;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic frame_ok(input string tag, input int w);
    send_frame(w, w);
    check({tag, " R3 no early strobe"}, early, 0);
    check({tag, " R3 strobe"}, got_valid, 1);
    for (int l = 0; l < NL; l++)
      check({tag, " R2 R4 lane word"}, sample_o[l*OW +: OW], expect_word(tx[l], w, sext_en));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid", valid_o, 0);
    check("R1 lock", lock_o, 0);
    check("R1 samples low", sample_o[31:0], 0);
    check("R1 samples high", sample_o[NL*OW-1:NL*OW-32], 0);
    rst = 1'b0;
  endtask

  task automatic t_stream14_lock;
    sext_en = 1'b1; mode_short = 1'b0;
    for (int k = 0; k < 5; k++) begin
      fill(k);
      if (k == 1) begin
        tx[0] = 14'h2000; tx[1] = 14'h1FFF; tx[2] = 14'h3FFF; tx[3] = 14'h0000;
        tx[4] = 14'h2AAA; tx[5] = 14'h1555; tx[6] = 14'h0001; tx[7] = 14'h2001;
      end
      frame_ok("R5 R6 14-bit sign-extended", W_LONG);
      check("R8 lock after frame", lock_o, (k == 4) ? 1 : 0);
    end
  endtask

  task automatic t_short_frame;
    for (int l = 0; l < NL; l++) tx[l] = 14'h3FFF;
    send_frame(W_LONG, 6);
    check("R10 no strobe for cut word", early + int'(got_valid), 0);
    check("R8 lock held before early marker", lock_o, 1);
    fill(7);
    frame_ok("R10 realigned word", W_LONG);
    check("R9 lock lost on early marker", lock_o, 0);
  endtask

  task automatic t_zero_fill;
    sext_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      fill(10 + k);
      tx[0] = 14'h2345; tx[1] = 14'h3FFF;
      frame_ok("R7 14-bit zero-filled", W_LONG);
    end
    check("R8 relock after four spacings", lock_o, 1);
  endtask

  task automatic t_late;
    idle(1);
    check("R9 lock lost on missing marker", lock_o, 0);
    check("R3 no strobe while idle", valid_o, 0);
    idle(3);
  endtask

  task automatic t_mode12;
    mode_short = 1'b1; sext_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      fill(20 + k);
      if (k == 2) begin
        tx[0] = 14'h0800; tx[1] = 14'h07FF; tx[2] = 14'h0FFF; tx[3] = 14'h0A5A;
      end
      frame_ok("R5 R6 12-bit sign-extended", W_SHORT);
      check("R5 R8 12-bit lock", lock_o, (k == 4) ? 1 : 0);
    end
    sext_en = 1'b0;
    for (int k = 0; k < 2; k++) begin
      fill(30 + k);
      tx[0] = 14'h0800; tx[1] = 14'h0FFF;
      frame_ok("R7 12-bit zero-filled", W_SHORT);
    end
    check("R8 lock kept in 12-bit run", lock_o, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_stream14_lock();
    t_short_frame();
    t_zero_fill();
    t_late();
    t_mode12();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule